// File: doc/BRIEF.md
# SONET Path Overhead Inserter

This block sits in the transmit path of an STS-3c or STS-1 framer. It takes the outgoing envelope one byte per clock, along with a strobe for the first envelope byte of each frame, a flag for bytes that belong to the envelope, and column/row markers that locate the path overhead column. It passes the stream through with one register stage and overwrites three path overhead bytes: the parity byte (row 1 of the overhead column), the signal label byte (row 2) and the path status byte (row 3).

The parity byte carries an even bit-interleaved parity over every envelope byte of the previous frame. The parity is taken over the bytes as they leave the block, so inserted overhead bytes are included. The signal label defaults to the ATM mapping code and can be replaced from a register. The status byte merges far-end error counts from the receive side with a forced diagnostic value and a remote defect flag. Pointer generation, section and line overhead, and scrambling are done elsewhere.

Top module: `poh_inserter`

## Requirements
- R1: After reset `out_data`, `out_spe_valid` and `out_frame_start` are 0, and the parity byte inserted in the first frame after reset is 8'h00.
- R2: Every input byte appears on `out_data` one clock later, with `out_spe_valid` and `out_frame_start` delayed by the same clock; bytes that are not the overhead slots of R3 to R8 are not changed.
- R3: An envelope byte with `in_poh_col`=1 and `in_row`=1 is replaced by the XOR of all envelope bytes (`in_spe_valid`=1) of the previous frame as they were output; a frame runs from one `in_frame_start` byte up to the byte before the next.
- R4: With `cfg_b3_corrupt`=1 the replaced byte of R3 has all eight bits inverted; the running parity still uses the byte actually sent.
- R5: The envelope byte at `in_poh_col`=1, `in_row`=2 is replaced by 8'h13, or by `cfg_c2_value` when `cfg_c2_override`=1.
- R6: The envelope byte at `in_poh_col`=1, `in_row`=3 carries in bits [7:4] the sum of all `rx_b3_err_count` values received with `rx_b3_err_valid` since that field was last sent, each count limited to 8 and the sum held at 8; sending it clears the sum, and a count arriving in the sending cycle starts the new sum.
- R7: With `cfg_febe_force`=1, bits [7:4] of the status byte take `cfg_febe_value` and the error sum is kept, not cleared.
- R8: Bit [3] of the status byte equals `cfg_rdi` and bits [2:0] are 0.
- R9: A byte with `in_spe_valid`=0 is never replaced, even when `in_poh_col`=1, and does not enter the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Outgoing byte from the framer |
| in_spe_valid | input | 1 | Byte belongs to the envelope |
| in_frame_start | input | 1 | First envelope byte of a frame |
| in_poh_col | input | 1 | Byte is in the path overhead column |
| in_row | input | 4 | Row index of the byte (0 to 8) |
| cfg_c2_override | input | 1 | Use `cfg_c2_value` as signal label |
| cfg_c2_value | input | 8 | Programmed signal label |
| cfg_b3_corrupt | input | 1 | Invert the inserted parity byte |
| cfg_febe_force | input | 1 | Send `cfg_febe_value` as error count |
| cfg_febe_value | input | 4 | Forced error count |
| cfg_rdi | input | 1 | Remote defect indication |
| rx_b3_err_valid | input | 1 | Receive-side parity error report present |
| rx_b3_err_count | input | 4 | Parity errors in one received frame |
| out_data | output | 8 | Byte with overhead inserted |
| out_spe_valid | output | 1 | Delayed `in_spe_valid` |
| out_frame_start | output | 1 | Delayed `in_frame_start` |

## Verification
Assertions watch every cycle for the one-clock latency and the untouched non-envelope bytes, the label and status-byte layout, the error sum never passing 8 and clearing after an unforced send, and the latched parity staying put between frame starts. Only the bench scenarios can show that the parity value carried into the next frame is the right one, that corruption and forcing leave the running state intact, and that clipped and saturated counts arrive in the right frame; the bench runs a series of frames that sweep each control through its settings and rebuilds the expected stream byte by byte.

// File: rtl/poh_pkg.sv
package poh_pkg;
  parameter int BYTE_W    = 8;
  parameter int FEBE_W    = 4;
  parameter int FEBE_MAX  = 8;
  parameter int ROW_W     = 4;
  parameter int ROW_PAR   = 1;
  parameter int ROW_LABEL = 2;
  parameter int ROW_STAT  = 3;
  parameter logic [BYTE_W-1:0] LABEL_ATM = 8'h13;

  // one step of the bit-interleaved parity
  function automatic logic [BYTE_W-1:0] bip_step(input logic [BYTE_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    return acc ^ b;
  endfunction

  // add a clipped count to a saturating sum
  function automatic logic [FEBE_W-1:0] febe_add(input logic [FEBE_W-1:0] acc,
                                                 input logic [FEBE_W-1:0] inc);
    logic [FEBE_W:0] clip;
    logic [FEBE_W:0] sum;
    clip = (inc > FEBE_W'(FEBE_MAX)) ? (FEBE_W+1)'(FEBE_MAX) : {1'b0, inc};
    sum  = {1'b0, acc} + clip;
    return (sum > (FEBE_W+1)'(FEBE_MAX)) ? FEBE_W'(FEBE_MAX) : sum[FEBE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic [FEBE_W-1:0] febe,
                                                    input logic rdi);
    return {febe, rdi, 3'b000};
  endfunction
endpackage

// File: rtl/poh_bip_acc.sv
module poh_bip_acc
  import poh_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_vld,
  input  logic         frame_first,
  input  logic [W-1:0] byte_in,
  output logic [W-1:0] bip_prev
);
  logic [W-1:0] running;
  logic         frame_edge;

  assign frame_edge = byte_vld & frame_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= '0;
      bip_prev <= '0;
    end else if (frame_edge) begin
      bip_prev <= running;
      running  <= byte_in;
    end else if (byte_vld) begin
      running  <= bip_step(running, byte_in);
    end
  end

  // latched parity changes only at a frame start
  assert_bip_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_edge |=> $stable(bip_prev));
endmodule

// File: rtl/poh_febe_acc.sv
module poh_febe_acc
  import poh_pkg::*;
#(
  parameter int W   = FEBE_W,
  parameter int MAX = FEBE_MAX
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err_vld,
  input  logic [W-1:0] err_cnt,
  input  logic         sent_clear,
  output logic [W-1:0] acc
);
  logic [W-1:0] base;
  logic [W-1:0] acc_nxt;

  always_comb begin
    base    = sent_clear ? '0 : acc;
    acc_nxt = err_vld ? febe_add(base, err_cnt) : base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_nxt;
  end

  assert_febe_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= W'(MAX));
  assert_febe_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_clear && !err_vld) |=> (acc == '0));
  assert_febe_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sent_clear && !err_vld) |=> $stable(acc));
endmodule

// File: rtl/poh_slot_mux.sv
module poh_slot_mux
  import poh_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int FW = FEBE_W
) (
  input  logic          slot_par,
  input  logic          slot_label,
  input  logic          slot_stat,
  input  logic [W-1:0]  byte_in,
  input  logic [W-1:0]  bip_prev,
  input  logic          corrupt,
  input  logic          label_ovr,
  input  logic [W-1:0]  label_val,
  input  logic          febe_force,
  input  logic [FW-1:0] febe_forced,
  input  logic [FW-1:0] febe_acc,
  input  logic          rdi,
  output logic [W-1:0]  byte_out
);
  logic [W-1:0]  par_byte;
  logic [W-1:0]  label_byte;
  logic [FW-1:0] febe_sent;

  always_comb begin
    par_byte   = bip_prev ^ {W{corrupt}};
    label_byte = label_ovr ? label_val : LABEL_ATM;
    febe_sent  = febe_force ? febe_forced : febe_acc;
    unique case (1'b1)
      slot_par:   byte_out = par_byte;
      slot_label: byte_out = label_byte;
      slot_stat:  byte_out = status_byte(febe_sent, rdi);
      default:    byte_out = byte_in;
    endcase
  end

  assert_one_slot_R2: assert final ($onehot0({slot_par, slot_label, slot_stat}));
endmodule

// File: rtl/poh_inserter.sv
module poh_inserter
  import poh_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int FW = FEBE_W,
  parameter int RW = ROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  in_data,
  input  logic          in_spe_valid,
  input  logic          in_frame_start,
  input  logic          in_poh_col,
  input  logic [RW-1:0] in_row,
  input  logic          cfg_c2_override,
  input  logic [W-1:0]  cfg_c2_value,
  input  logic          cfg_b3_corrupt,
  input  logic          cfg_febe_force,
  input  logic [FW-1:0] cfg_febe_value,
  input  logic          cfg_rdi,
  input  logic          rx_b3_err_valid,
  input  logic [FW-1:0] rx_b3_err_count,
  output logic [W-1:0]  out_data,
  output logic          out_spe_valid,
  output logic          out_frame_start
);
  // named slot events
  logic          poh_byte;
  logic          slot_par;
  logic          slot_label;
  logic          slot_stat;
  logic          febe_sent_clear;
  logic [W-1:0]  bip_prev;
  logic [FW-1:0] febe_acc;
  logic [W-1:0]  byte_nxt;

  assign poh_byte        = in_spe_valid & in_poh_col;
  assign slot_par        = poh_byte & (in_row == RW'(ROW_PAR));
  assign slot_label      = poh_byte & (in_row == RW'(ROW_LABEL));
  assign slot_stat       = poh_byte & (in_row == RW'(ROW_STAT));
  assign febe_sent_clear = slot_stat & ~cfg_febe_force;

  poh_slot_mux #(.W(W), .FW(FW)) u_mux (
    .slot_par    (slot_par),
    .slot_label  (slot_label),
    .slot_stat   (slot_stat),
    .byte_in     (in_data),
    .bip_prev    (bip_prev),
    .corrupt     (cfg_b3_corrupt),
    .label_ovr   (cfg_c2_override),
    .label_val   (cfg_c2_value),
    .febe_force  (cfg_febe_force),
    .febe_forced (cfg_febe_value),
    .febe_acc    (febe_acc),
    .rdi         (cfg_rdi),
    .byte_out    (byte_nxt)
  );

  poh_bip_acc #(.W(W)) u_bip (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (in_spe_valid),
    .frame_first (in_frame_start),
    .byte_in     (byte_nxt),
    .bip_prev    (bip_prev)
  );

  poh_febe_acc #(.W(FW), .MAX(FEBE_MAX)) u_febe (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_vld    (rx_b3_err_valid),
    .err_cnt    (rx_b3_err_count),
    .sent_clear (febe_sent_clear),
    .acc        (febe_acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data        <= '0;
      out_spe_valid   <= 1'b0;
      out_frame_start <= 1'b0;
    end else begin
      out_data        <= byte_nxt;
      out_spe_valid   <= in_spe_valid;
      out_frame_start <= in_frame_start;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_spe_valid == $past(in_spe_valid)) &&
             (out_frame_start == $past(in_frame_start)));
  assert_nonspe_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_spe_valid |=> (out_data == $past(in_data)));
  assert_label_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_label && !cfg_c2_override) |=> (out_data == LABEL_ATM));
  assert_status_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stat |=> (out_data[2:0] == 3'b000) && (out_data[3] == $past(cfg_rdi)));
  assert_status_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stat && cfg_febe_force) |=> (out_data[7:4] == $past(cfg_febe_value)));
endmodule

// File: tb/test_poh_inserter.sv
module test_poh_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_spe_valid = 1'b0;
  logic       in_frame_start = 1'b0;
  logic       in_poh_col = 1'b0;
  logic [3:0] in_row = '0;
  logic       cfg_c2_override = 1'b0;
  logic [7:0] cfg_c2_value = '0;
  logic       cfg_b3_corrupt = 1'b0;
  logic       cfg_febe_force = 1'b0;
  logic [3:0] cfg_febe_value = '0;
  logic       cfg_rdi = 1'b0;
  logic       rx_b3_err_valid = 1'b0;
  logic [3:0] rx_b3_err_count = '0;
  logic [7:0] out_data;
  logic       out_spe_valid;
  logic       out_frame_start;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model state
  int m_run  = 0;
  int m_prev = 0;
  int m_febe = 0;

  always #2.5 clk = ~clk;

  poh_inserter i_poh_inserter (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_spe_valid(in_spe_valid),
    .in_frame_start(in_frame_start), .in_poh_col(in_poh_col), .in_row(in_row),
    .cfg_c2_override(cfg_c2_override), .cfg_c2_value(cfg_c2_value),
    .cfg_b3_corrupt(cfg_b3_corrupt), .cfg_febe_force(cfg_febe_force),
    .cfg_febe_value(cfg_febe_value), .cfg_rdi(cfg_rdi),
    .rx_b3_err_valid(rx_b3_err_valid), .rx_b3_err_count(rx_b3_err_count),
    .out_data(out_data), .out_spe_valid(out_spe_valid),
    .out_frame_start(out_frame_start)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // drive one byte, predict, clock, compare
  task automatic cyc(input int d, input bit spe, input bit fs, input bit pc,
                     input int row, input bit ev, input int ec);
    int    exp;
    int    fe;
    int    inc;
    string tag;
    bit    sent;
    in_data = 8'(d); in_spe_valid = spe; in_frame_start = fs;
    in_poh_col = pc; in_row = 4'(row);
    rx_b3_err_valid = ev; rx_b3_err_count = 4'(ec);
    exp = d & 255; tag = spe ? "R2" : "R9"; sent = 1'b0;
    if (spe && pc && row == 1) begin
      exp = cfg_b3_corrupt ? (255 - m_prev) : m_prev;
      tag = cfg_b3_corrupt ? "R4" : "R3";
    end else if (spe && pc && row == 2) begin
      exp = cfg_c2_override ? int'(cfg_c2_value) : 19; tag = "R5";
    end else if (spe && pc && row == 3) begin
      fe  = cfg_febe_force ? int'(cfg_febe_value) : m_febe;
      exp = fe * 16 + (cfg_rdi ? 8 : 0);
      tag = cfg_febe_force ? "R7/R8" : "R6/R8";
      sent = !cfg_febe_force;
    end
    if (sent) m_febe = 0;
    if (ev) begin
      inc = (ec > 8) ? 8 : ec;
      m_febe = (m_febe + inc > 8) ? 8 : m_febe + inc;
    end
    if (spe) begin
      if (fs) begin m_prev = m_run; m_run = exp; end
      else m_run = m_run ^ exp;
    end
    @(posedge clk); #1;
    check(tag, int'(out_data), exp);
    check("R2 valid", int'(out_spe_valid), int'(spe));
    check("R2 start", int'(out_frame_start), int'(fs));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 data", int'(out_data), 0);
    check("R1 valid", int'(out_spe_valid), 0);
    check("R1 start", int'(out_frame_start), 0);
    rst_n = 1'b1;
    for (int f = 0; f < 14; f++) begin
      cfg_b3_corrupt  = (f == 4) || (f == 9);
      cfg_c2_override = (f % 5 == 2);
      cfg_c2_value    = 8'(f * 17 + 3);
      cfg_febe_force  = (f == 6) || (f == 7);
      cfg_febe_value  = 4'(f + 5);
      cfg_rdi         = f[0];
      for (int r = 0; r < 9; r++) begin
        // non-envelope byte marked as overhead column: R9
        cyc(f * 37 + r * 11 + 201, 1'b0, 1'b0, 1'b1, r, 1'b0, 0);
        // overhead byte; error report in the status slot on some frames
        cyc(f * 29 + r * 7 + 90, 1'b1, r == 0, 1'b1, r,
            (r == 3) && (f % 3 == 0), (f * 5) % 16);
        for (int k = 0; k < 6; k++)
          cyc(f * 13 + r * 19 + k * 5 + 1, 1'b1, 1'b0, 1'b0, r,
              (r == 5) && (k == 2), (f * 3) % 11);
      end
    end
    // one more frame start to expose the last parity
    cyc(5, 1'b1, 1'b1, 1'b1, 0, 1'b0, 0);
    cyc(6, 1'b1, 1'b0, 1'b1, 1, 1'b0, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule